// File: doc/BRIEF.md
# Config-Space Data-Object Mailbox Register Interface

This block is the device-side register file of a configuration-space mailbox that moves whole data objects between host software and an on-chip responder. Software issues dword accesses at fixed offsets within the capability. It loads a request object one dword at a time through a write-data register and then sets the GO control bit. The block checks the object length carried in the second header dword. If the length is valid, it streams the request to the responder over a valid/ready channel.

The responder answers over a second valid/ready stream. The block buffers the whole response, raises Data Object Ready and presents the response one dword at a time on a read-data register. Software advances that register by writing any value to it. An abort control bit returns the mailbox to idle from any state. When interrupts are enabled, a one-cycle interrupt-request pulse marks the arrival of a response. Decoding of configuration packets and delivery of message interrupts belong to the surrounding logic.

Top module: `cfg_mbox_regif`

## Requirements
- R1: After reset, the control, status and read-data registers all read zero. An access at an unmapped or misaligned offset reads zero.
- R2: The capabilities register sits at offset 0x04. Its bit 0 reads the interrupt-support parameter and its bits 11:1 read the interrupt message number parameter.
- R3: The control register sits at offset 0x08. Bit 1 (interrupt enable) reads back the last value written to it. Bit 0 (abort) and bit 31 (GO) always read zero.
- R4: Dwords written to offset 0x10 are buffered. After a valid GO they leave on the request stream in write order, and req_last marks the final dword. Status bit 0 (Busy) is set from the GO until the last response dword has been accepted.
- R5: Bits 17:0 of the second written dword give the total object length in dwords, headers included. If GO is written while that length is below 2, or differs from the number of dwords written, status bit 2 (Error) is set, nothing is sent and the request is discarded.
- R6: The response stream is accepted until rsp_last. At that point status bit 31 (Data Object Ready) sets and Busy clears.
- R7: A read at offset 0x14 returns the current response dword. Any write to 0x14 advances to the next dword. Data Object Ready stays set while unread dwords remain and clears after the last one is acknowledged. While it is clear, 0x14 reads zero.
- R8: With interrupt enable set, irq_pulse is high for exactly one cycle, the cycle in which Data Object Ready rises. Status bit 1 (Interrupt Status) sets in that same cycle. With interrupt enable clear, neither happens.
- R9: Writing 1 to status bit 1 clears Interrupt Status. Writing 0 there leaves it unchanged.
- R10: Writing 1 to control bit 0 (abort) clears Error, Busy and Data Object Ready and discards any partial request or response. Abort takes priority over GO written in the same access.
- R11: A write to offset 0x10 while the mailbox is busy or holding a response, or while the request buffer is full, sets Error and the dword is dropped.
- R12: While Error is set, GO is ignored: Busy stays clear and nothing is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_valid | input | 1 | Register access strobe, one cycle per access |
| cfg_write | input | 1 | 1 for write, 0 for read |
| cfg_addr | input | ADDR_W | Byte offset within the capability |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for cfg_addr, combinational |
| req_valid | output | 1 | Request dword valid |
| req_ready | input | 1 | Responder accepts request dword |
| req_data | output | 32 | Request dword |
| req_last | output | 1 | Final dword of the request object |
| rsp_valid | input | 1 | Response dword valid |
| rsp_ready | output | 1 | Block accepts response dword |
| rsp_data | input | 32 | Response dword |
| rsp_last | input | 1 | Final dword of the response object |
| irq_pulse | output | 1 | One-cycle interrupt request |

## Verification
A sequencer that reaches a wrong state shows up in the status register at the very next read. Typical symptoms are Busy and Data Object Ready set together, Busy stuck after the response completes, or Error missing after a malformed GO. A corrupted request buffer shows up on the request stream within as many cycles as the object has dwords, as reordered or missing data or a misplaced req_last. A miscounted response buffer appears at offset 0x14: Data Object Ready drops one acknowledge too early or too late, or the read register returns stale data after an abort. An interrupt fault appears as a missing, doubled or stretched irq_pulse in the cycle after the final response dword.

// File: rtl/cfg_mbox_pkg.sv
// Shared constants and types for the config-space mailbox register block.
// Assumes dword-aligned byte offsets inside the capability.
package cfg_mbox_pkg;
    localparam int unsigned DATA_W  = 32;
    localparam int unsigned LEN_W   = 18;

    // Byte offsets of the registers inside the capability
    localparam logic [7:0] OFS_CAP  = 8'h04;
    localparam logic [7:0] OFS_CTRL = 8'h08;
    localparam logic [7:0] OFS_STAT = 8'h0C;
    localparam logic [7:0] OFS_WMBX = 8'h10;
    localparam logic [7:0] OFS_RMBX = 8'h14;

    // Control bits
    localparam int unsigned CB_ABORT = 0;
    localparam int unsigned CB_INTEN = 1;
    localparam int unsigned CB_GO    = 31;

    // Status bits
    localparam int unsigned SB_BUSY  = 0;
    localparam int unsigned SB_INTST = 1;
    localparam int unsigned SB_ERR   = 2;
    localparam int unsigned SB_DOR   = 31;

    typedef enum logic [1:0] {
        MB_IDLE    = 2'd0,
        MB_SEND    = 2'd1,
        MB_COLLECT = 2'd2,
        MB_READY   = 2'd3
    } mb_state_e;
endpackage

// File: rtl/cfg_mbox_fifo.sv
// Synchronous dword FIFO with occupancy count and clear.
// Assumes the caller never pushes when full nor pops when empty.
module cfg_mbox_fifo #(
    parameter int unsigned W     = 32,
    parameter int unsigned DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    input  logic                         push,
    input  logic [W-1:0]                 wdata,
    input  logic                         pop,
    output logic [W-1:0]                 rdata,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         full,
    output logic                         empty
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH+1);
    localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH-1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt_q;

    // Storage write; no reset needed on the data array
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= wdata;
    end

    // Pointer and occupancy bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
            if (push && !pop)      cnt_q <= cnt_q + 1'b1;
            else if (pop && !push) cnt_q <= cnt_q - 1'b1;
        end
    end

    assign rdata = mem[rd_ptr];
    assign count = cnt_q;
    assign full  = (cnt_q == CW'(DEPTH));
    assign empty = (cnt_q == '0);

    AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !clr) |-> !full); // R11
    AST_FIFO_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !clr) |-> !empty); // R7
endmodule

// File: rtl/cfg_mbox_ctrl.sv
// Object-level sequencer: GO/abort handling, length check, request send,
// response collection, ready/error/busy flags and interrupt generation.
// Assumes the register decode gives one-cycle strobes per access.
module cfg_mbox_ctrl
    import cfg_mbox_pkg::*;
#(
    parameter int unsigned REQ_DEPTH     = 16,
    parameter int unsigned RSP_DEPTH     = 16,
    parameter bit          INT_SUPPORTED = 1'b1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_ctrl,
    input  logic                            ctrl_abort,
    input  logic                            ctrl_go,
    input  logic                            ctrl_inten,
    input  logic                            wr_stat,
    input  logic                            stat_intclr,
    input  logic                            wr_wmbx,
    input  logic                            wr_rmbx,
    input  logic [LEN_W-1:0]                obj_len,
    input  logic [$clog2(REQ_DEPTH+1)-1:0]  req_cnt,
    input  logic                            req_full,
    input  logic                            req_empty,
    input  logic                            req_ready_i,
    input  logic                            rsp_valid_i,
    input  logic                            rsp_last_i,
    input  logic                            rsp_full,
    input  logic [$clog2(RSP_DEPTH+1)-1:0]  rsp_cnt,
    output logic                            req_push,
    output logic                            req_pop,
    output logic                            req_clr,
    output logic                            req_valid_o,
    output logic                            rsp_push,
    output logic                            rsp_pop,
    output logic                            rsp_clr,
    output logic                            rsp_ready_o,
    output logic                            go_ok,
    output logic                            busy,
    output logic                            error,
    output logic                            dor,
    output logic                            int_en,
    output logic                            int_sts,
    output logic                            irq
);
    localparam int unsigned RCW = $clog2(REQ_DEPTH+1);
    localparam int unsigned SCW = $clog2(RSP_DEPTH+1);

    mb_state_e state_q, state_d;
    logic      err_q, ists_q, irq_q;
    logic      abort, go, len_bad, wm_bad, rsp_acc, rsp_ovf, enter_ready;

    // Decode of object-level events from register strobes
    always_comb begin
        abort    = wr_ctrl && ctrl_abort;
        go       = wr_ctrl && ctrl_go && !abort && !err_q && (state_q == MB_IDLE);
        len_bad  = (obj_len < LEN_W'(2)) || (obj_len != LEN_W'(req_cnt));
        go_ok    = go && !len_bad;
        wm_bad   = wr_wmbx && ((state_q != MB_IDLE) || req_full);
        req_push = wr_wmbx && !wm_bad && !err_q;
        req_valid_o = (state_q == MB_SEND) && !req_empty;
        req_pop  = req_valid_o && req_ready_i && !abort;
        rsp_ready_o = (state_q == MB_COLLECT);
        rsp_acc  = rsp_valid_i && rsp_ready_o && !abort;
        rsp_push = rsp_acc && !rsp_full;
        rsp_ovf  = rsp_acc && rsp_full;
        rsp_pop  = wr_rmbx && (state_q == MB_READY) && !abort;
        req_clr  = abort || (go && len_bad);
        rsp_clr  = abort || rsp_ovf;
        enter_ready = rsp_push && rsp_last_i;
    end

    // Next-state selection of the object sequencer
    always_comb begin
        state_d = state_q;
        if (abort) begin
            state_d = MB_IDLE;
        end else begin
            unique case (state_q)
                MB_IDLE:    if (go_ok) state_d = MB_SEND;
                MB_SEND:    if (req_pop && req_cnt == RCW'(1)) state_d = MB_COLLECT;
                MB_COLLECT: if (rsp_ovf) state_d = MB_IDLE;
                            else if (enter_ready) state_d = MB_READY;
                MB_READY:   if (rsp_pop && rsp_cnt == SCW'(1)) state_d = MB_IDLE;
                default:    state_d = MB_IDLE;
            endcase
        end
    end

    // State, error, interrupt status and pulse registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= MB_IDLE;
            err_q   <= 1'b0;
            ists_q  <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (abort)                                 err_q <= 1'b0;
            else if ((go && len_bad) || wm_bad || rsp_ovf) err_q <= 1'b1;
            if (enter_ready && int_en)                 ists_q <= 1'b1;
            else if (wr_stat && stat_intclr)           ists_q <= 1'b0;
            irq_q <= enter_ready && int_en;
        end
    end

    // Interrupt enable exists only when interrupts are supported
    generate
        if (INT_SUPPORTED) begin : g_inten
            logic inten_q;
            // Capture interrupt enable on every control write
            always_ff @(posedge clk) begin
                if (!rst_n)       inten_q <= 1'b0;
                else if (wr_ctrl) inten_q <= ctrl_inten;
            end
            assign int_en = inten_q;
        end else begin : g_nointen
            assign int_en = 1'b0;
        end
    endgenerate

    assign busy    = (state_q == MB_SEND) || (state_q == MB_COLLECT);
    assign dor     = (state_q == MB_READY);
    assign error   = err_q;
    assign int_sts = ists_q;
    assign irq     = irq_q;

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R8
    AST_IRQ_WITH_READY: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (dor && int_sts)); // R8
    AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (!busy && !dor && !error)); // R10
    AST_BADLEN_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
        (go && len_bad) |=> (error && !busy)); // R5
    AST_READY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (dor && !wr_rmbx && !abort) |=> dor); // R7
    AST_GO_BLOCKED_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && ctrl_go && error && !busy && !dor) |=> !busy); // R12
endmodule

// File: rtl/cfg_mbox_regif.sv
// Top of the config-space mailbox: register decode, request and response
// buffers, header length capture and the object sequencer.
// Assumes one cycle per access and combinational read data.
module cfg_mbox_regif
    import cfg_mbox_pkg::*;
#(
    parameter int unsigned ADDR_W        = 12,
    parameter int unsigned REQ_DEPTH     = 16,
    parameter int unsigned RSP_DEPTH     = 16,
    parameter bit          INT_SUPPORTED = 1'b1,
    parameter logic [10:0] INT_MSG_NUM   = 11'd5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_valid,
    input  logic              cfg_write,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [31:0]       req_data,
    output logic              req_last,
    input  logic              rsp_valid,
    output logic              rsp_ready,
    input  logic [31:0]       rsp_data,
    input  logic              rsp_last,
    output logic              irq_pulse
);
    localparam int unsigned RCW = $clog2(REQ_DEPTH+1);
    localparam int unsigned SCW = $clog2(RSP_DEPTH+1);

    logic           sel_cap, sel_ctrl, sel_stat, sel_wmbx, sel_rmbx;
    logic           wr_ctrl, wr_stat, wr_wmbx, wr_rmbx;
    logic           req_push, req_pop, req_clr, req_full, req_empty;
    logic           rsp_push, rsp_pop, rsp_clr, rsp_full, rsp_empty;
    logic [RCW-1:0] req_cnt;
    logic [SCW-1:0] rsp_cnt;
    logic [31:0]    rsp_head;
    logic [LEN_W-1:0] len_q;
    logic           go_ok, busy, error, dor, int_en, int_sts;

    // Register select decode on full byte offset
    always_comb begin
        sel_cap  = (cfg_addr == ADDR_W'(OFS_CAP));
        sel_ctrl = (cfg_addr == ADDR_W'(OFS_CTRL));
        sel_stat = (cfg_addr == ADDR_W'(OFS_STAT));
        sel_wmbx = (cfg_addr == ADDR_W'(OFS_WMBX));
        sel_rmbx = (cfg_addr == ADDR_W'(OFS_RMBX));
        wr_ctrl  = cfg_valid && cfg_write && sel_ctrl;
        wr_stat  = cfg_valid && cfg_write && sel_stat;
        wr_wmbx  = cfg_valid && cfg_write && sel_wmbx;
        wr_rmbx  = cfg_valid && cfg_write && sel_rmbx;
    end

    // Read data multiplexer
    always_comb begin
        cfg_rdata = '0;
        if (sel_cap) begin
            cfg_rdata[0]    = INT_SUPPORTED;
            cfg_rdata[11:1] = INT_MSG_NUM;
        end else if (sel_ctrl) begin
            cfg_rdata[CB_INTEN] = int_en;
        end else if (sel_stat) begin
            cfg_rdata[SB_BUSY]  = busy;
            cfg_rdata[SB_INTST] = int_sts;
            cfg_rdata[SB_ERR]   = error;
            cfg_rdata[SB_DOR]   = dor;
        end else if (sel_rmbx) begin
            cfg_rdata = (dor && !rsp_empty) ? rsp_head : '0;
        end
    end

    // Capture the length field when the second request dword is written
    always_ff @(posedge clk) begin
        if (!rst_n || req_clr || go_ok)         len_q <= '0;
        else if (req_push && req_cnt == RCW'(1)) len_q <= cfg_wdata[LEN_W-1:0];
    end

    cfg_mbox_fifo #(.W(32), .DEPTH(REQ_DEPTH)) u_req_buf (
        .clk(clk), .rst_n(rst_n), .clr(req_clr),
        .push(req_push), .wdata(cfg_wdata), .pop(req_pop),
        .rdata(req_data), .count(req_cnt), .full(req_full), .empty(req_empty)
    );

    cfg_mbox_fifo #(.W(32), .DEPTH(RSP_DEPTH)) u_rsp_buf (
        .clk(clk), .rst_n(rst_n), .clr(rsp_clr),
        .push(rsp_push), .wdata(rsp_data), .pop(rsp_pop),
        .rdata(rsp_head), .count(rsp_cnt), .full(rsp_full), .empty(rsp_empty)
    );

    cfg_mbox_ctrl #(
        .REQ_DEPTH(REQ_DEPTH), .RSP_DEPTH(RSP_DEPTH), .INT_SUPPORTED(INT_SUPPORTED)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .wr_ctrl(wr_ctrl), .ctrl_abort(cfg_wdata[CB_ABORT]),
        .ctrl_go(cfg_wdata[CB_GO]), .ctrl_inten(cfg_wdata[CB_INTEN]),
        .wr_stat(wr_stat), .stat_intclr(cfg_wdata[SB_INTST]),
        .wr_wmbx(wr_wmbx), .wr_rmbx(wr_rmbx), .obj_len(len_q),
        .req_cnt(req_cnt), .req_full(req_full), .req_empty(req_empty),
        .req_ready_i(req_ready), .rsp_valid_i(rsp_valid), .rsp_last_i(rsp_last),
        .rsp_full(rsp_full), .rsp_cnt(rsp_cnt),
        .req_push(req_push), .req_pop(req_pop), .req_clr(req_clr),
        .req_valid_o(req_valid), .rsp_push(rsp_push), .rsp_pop(rsp_pop),
        .rsp_clr(rsp_clr), .rsp_ready_o(rsp_ready), .go_ok(go_ok),
        .busy(busy), .error(error), .dor(dor), .int_en(int_en),
        .int_sts(int_sts), .irq(irq_pulse)
    );

    assign req_last = req_valid && (req_cnt == RCW'(1));

    AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready && !wr_ctrl) |=> (req_valid && $stable(req_data))); // R4
    AST_BUSY_SET_AFTER_GO: assert property (@(posedge clk) disable iff (!rst_n)
        go_ok |=> busy); // R4
endmodule

// File: tb/cfg_mbox_regif_tb.sv
// Directed bench for the mailbox register interface; one task per scenario.
module cfg_mbox_regif_tb_top;
    localparam logic [11:0] A_CAP  = 12'h004;
    localparam logic [11:0] A_CTRL = 12'h008;
    localparam logic [11:0] A_STAT = 12'h00C;
    localparam logic [11:0] A_WMBX = 12'h010;
    localparam logic [11:0] A_RMBX = 12'h014;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_valid = 1'b0, cfg_write = 1'b0;
    logic [11:0] cfg_addr = '0;
    logic [31:0] cfg_wdata = '0, cfg_rdata;
    logic        req_valid, req_ready = 1'b0, req_last;
    logic [31:0] req_data;
    logic        rsp_valid = 1'b0, rsp_ready, rsp_last = 1'b0;
    logic [31:0] rsp_data = '0;
    logic        irq_pulse;

    int tests = 0, fails = 0;
    int req_n = 0, irq_n = 0;
    logic [31:0] req_log [32];
    logic        last_log [32];
    logic [31:0] rd;

    always #4 clk = ~clk;

    cfg_mbox_regif dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_write(cfg_write),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_data(req_data),
        .req_last(req_last), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_data(rsp_data), .rsp_last(rsp_last), .irq_pulse(irq_pulse)
    );

    // Observe request transfers and interrupt pulses between edges
    always @(negedge clk) begin
        if (rst_n && req_valid && req_ready && req_n < 32) begin
            req_log[req_n]  = req_data;
            last_log[req_n] = req_last;
            req_n++;
        end
        if (rst_n && irq_pulse) irq_n++;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cfg_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_valid = 1'b1; cfg_write = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_valid = 1'b0; cfg_write = 1'b0;
    endtask

    task automatic cfg_rd(input logic [11:0] a, output logic [31:0] d);
        cfg_valid = 1'b1; cfg_write = 1'b0; cfg_addr = a;
        #1 d = cfg_rdata;
        cfg_valid = 1'b0;
    endtask

    task automatic wait_req(input int n);
        for (int i = 0; i < 60 && req_n < n; i++) @(negedge clk);
    endtask

    task automatic send_rsp(input int n, input bit with_last);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            rsp_valid = 1'b1; rsp_data = 32'hB000_0000 + k;
            rsp_last = with_last && (k == n - 1);
            #1;
            for (int t = 0; t < 60 && !rsp_ready; t++) begin @(negedge clk); #1; end
        end
        @(negedge clk);
        rsp_valid = 1'b0; rsp_last = 1'b0;
    endtask

    task automatic load_req(input int n_total, input logic [31:0] len);
        cfg_wr(A_WMBX, 32'h0002_1E0F);
        if (n_total > 1) cfg_wr(A_WMBX, len);
        for (int k = 2; k < n_total; k++) cfg_wr(A_WMBX, 32'hA000_0000 + k);
    endtask

    task automatic t_reset();
        cfg_rd(A_STAT, rd); chk("R1 status after reset", rd, 32'h0);
        cfg_rd(A_CTRL, rd); chk("R1 control after reset", rd, 32'h0);
        cfg_rd(A_RMBX, rd); chk("R1 read mailbox after reset", rd, 32'h0);
        cfg_rd(12'h006, rd); chk("R1 misaligned offset", rd, 32'h0);
        cfg_rd(A_CAP, rd);  chk("R2 capabilities", rd, 32'h0000_000B);
    endtask

    task automatic t_ctrl_rb();
        cfg_wr(A_CTRL, 32'h8000_0003);
        cfg_rd(A_CTRL, rd); chk("R3 control readback", rd, 32'h2);
        cfg_rd(A_STAT, rd); chk("R10 abort+go leaves idle", rd, 32'h0);
        cfg_wr(A_CTRL, 32'h0);
        cfg_rd(A_CTRL, rd); chk("R3 control cleared", rd, 32'h0);
    endtask

    task automatic t_exchange(input int nq, input int ns, input bit ie);
        int irq0;
        req_ready = 1'b1; req_n = 0; irq0 = irq_n;
        load_req(nq, nq);
        cfg_wr(A_CTRL, 32'h8000_0000 | (ie ? 32'h2 : 32'h0));
        cfg_rd(A_STAT, rd); chk("R4 busy after GO", rd & 32'h8000_0001, 32'h1);
        wait_req(nq);
        chk("R4 request count", req_n, nq);
        chk("R4 first dword", req_log[0], 32'h0002_1E0F);
        chk("R4 length dword", req_log[1], nq);
        for (int k = 2; k < nq; k++) chk("R4 payload order", req_log[k], 32'hA000_0000 + k);
        for (int k = 0; k < nq; k++) chk("R4 last flag", 32'(last_log[k]), 32'(k == nq - 1));
        send_rsp(ns, 1'b1);
        #1 chk("R8 irq pulse on ready", 32'(irq_pulse), 32'(ie));
        cfg_rd(A_STAT, rd);
        chk("R6 ready set busy clear", rd, 32'h8000_0000 | (ie ? 32'h2 : 32'h0));
        @(negedge clk); #1 chk("R8 irq one cycle", 32'(irq_pulse), 32'h0);
        for (int k = 0; k < ns; k++) begin
            cfg_rd(A_RMBX, rd); chk("R7 response dword", rd, 32'hB000_0000 + k);
            cfg_rd(A_STAT, rd); chk("R7 ready held", rd[31], 1'b1);
            cfg_wr(A_RMBX, 32'hFFFF_FFFF);
        end
        cfg_rd(A_STAT, rd); chk("R7 ready cleared", rd & 32'h8000_0005, 32'h0);
        cfg_rd(A_RMBX, rd); chk("R7 empty read", rd, 32'h0);
        chk("R8 irq count", irq_n - irq0, ie ? 1 : 0);
    endtask

    task automatic t_intclr();
        cfg_wr(A_STAT, 32'h0);
        cfg_rd(A_STAT, rd); chk("R9 write 0 keeps status", rd, 32'h2);
        cfg_wr(A_STAT, 32'h2);
        cfg_rd(A_STAT, rd); chk("R9 write 1 clears status", rd, 32'h0);
    endtask

    task automatic t_badlen();
        req_ready = 1'b1; req_n = 0;
        load_req(2, 32'h1);
        cfg_wr(A_CTRL, 32'h8000_0000);
        cfg_rd(A_STAT, rd); chk("R5 length below two", rd, 32'h4);
        cfg_wr(A_CTRL, 32'h8000_0000);
        repeat (4) @(negedge clk);
        cfg_rd(A_STAT, rd); chk("R12 go ignored on error", rd, 32'h4);
        chk("R5 R12 nothing sent", req_n, 0);
        cfg_wr(A_CTRL, 32'h1);
        cfg_rd(A_STAT, rd); chk("R10 abort clears error", rd, 32'h0);
        load_req(3, 32'h5);
        cfg_wr(A_CTRL, 32'h8000_0000);
        repeat (4) @(negedge clk);
        cfg_rd(A_STAT, rd); chk("R5 length mismatch", rd, 32'h4);
        chk("R5 mismatch nothing sent", req_n, 0);
        cfg_wr(A_CTRL, 32'h1);
    endtask

    task automatic t_wr_busy();
        req_ready = 1'b0; req_n = 0;
        load_req(2, 32'h2);
        cfg_wr(A_CTRL, 32'h8000_0000);
        cfg_wr(A_WMBX, 32'h1234_5678);
        cfg_rd(A_STAT, rd); chk("R11 write while busy", rd, 32'h5);
        cfg_wr(A_CTRL, 32'h1);
        cfg_rd(A_STAT, rd); chk("R10 abort while sending", rd, 32'h0);
        #1 chk("R10 request dropped", 32'(req_valid), 32'h0);
        req_ready = 1'b1;
    endtask

    task automatic t_abort_mid();
        req_ready = 1'b1; req_n = 0;
        load_req(2, 32'h2);
        cfg_wr(A_CTRL, 32'h8000_0000);
        wait_req(2);
        send_rsp(1, 1'b0);
        cfg_rd(A_STAT, rd); chk("R6 still busy mid response", rd, 32'h1);
        cfg_wr(A_CTRL, 32'h1);
        cfg_rd(A_STAT, rd); chk("R10 abort mid response", rd, 32'h0);
        cfg_rd(A_RMBX, rd); chk("R10 response discarded", rd, 32'h0);
        load_req(3, 32'h3);
        cfg_wr(A_CTRL, 32'h1);
    endtask

    task automatic finish_up();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; tests++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ctrl_rb();
        t_exchange(4, 3, 1'b1);
        t_intclr();
        t_exchange(2, 1, 1'b0);
        t_badlen();
        t_wr_busy();
        t_abort_mid();
        t_exchange(5, 6, 1'b1);
        t_intclr();
        finish_up();
    end
endmodule